// File: doc/BRIEF.md
# Packed-Lane Unit Arithmetic and Condition Evaluator

This block is the unit-operation execution slice of a 64-bit integer ALU. It performs a bitwise XOR, an add-with-complement (a + ~b), a plain add or a plain subtract on two 64-bit operands. In the same pass it evaluates a 4-bit condition across every packed lane of the result at once. A condition can ask whether any word, halfword or byte lane of the result is zero. It can also ask whether any nibble, byte, halfword or word lane produced a carry out of its top bit. The carry vector is rebuilt from the two effective operands and the sum, so all lanes are tested in parallel from one 64-bit adder.

Pipeline logic presents one operation per cycle with `inValid`. One cycle later the block returns the result together with a register-write enable and a flag that tells the pipeline to nullify the following instruction. When trapping is enabled and the condition holds, the block raises a one-cycle trap request and withholds the register write. A 32-bit mode restricts every lane test to the low half of the datapath.

Top module: `unit_cond_eval`

## Requirements
- R1: A synchronous reset drives `outValid`, `writeEn`, `nullifyNext`, `trapReq` and `result` to zero on the next clock edge.
- R2: `outValid` equals `inValid` delayed by one clock. `result` is captured on a valid cycle and holds its value through cycles without `inValid`.
- R3: `opSel` selects the result: 0 gives a XOR b, 1 gives a + ~b, 2 gives a + b and 3 gives a − b. All results are modulo 2^64.
- R4: `condField[3:1]` selects the test and `condField[0]` inverts it. Test code 0 is never true, so with the inversion bit set it is always true.
- R5: Test 1 is true if any 32-bit word of the result is zero. Test 2 is true if any byte is zero. Test 3 is true if any 16-bit halfword is zero.
- R6: Test 4 is true on a carry out of any of bits 3, 7, 11, … (the nibble tops). Test 5 uses bits 31 and 63. Test 6 uses bits 7, 15, … (the byte tops). Test 7 uses bits 15, 31, … (the halfword tops). The carry out of bit k is that of the chosen operation: a+b, a+~b+1 for subtract, or a+~b with no carry-in for opSel 1.
- R7: With `dwordMode` low, the zero and carry tests look only at lanes inside bits 31..0.
- R8: With `dwordMode` low, tests 1 and 5 behave as test 0: never true, and always true when inverted.
- R9: With opSel 0 (XOR), tests 4 to 7 behave as test 0.
- R10: If `trapEn` is high and the condition is true on a valid cycle, the following cycle shows `trapReq`=1, `writeEn`=0 and `nullifyNext`=0.
- R11: Otherwise a valid cycle yields `writeEn`=1, `trapReq`=0 and `nullifyNext` equal to the condition.
- R12: In a cycle where `outValid` is low, `writeEn`, `nullifyNext` and `trapReq` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Operation present this cycle |
| opSel | input | 2 | 0 XOR, 1 add-complement, 2 add, 3 subtract |
| operandA | input | 64 | First operand |
| operandB | input | 64 | Second operand |
| condField | input | 4 | Test select in bits 3..1, invert in bit 0 |
| dwordMode | input | 1 | 1 = 64-bit lane tests, 0 = low 32 bits only |
| trapEn | input | 1 | Turn a true condition into a trap |
| outValid | output | 1 | Result stage valid |
| result | output | 64 | Registered result |
| writeEn | output | 1 | Write the result to the destination |
| nullifyNext | output | 1 | Condition true; skip the next instruction |
| trapReq | output | 1 | One-cycle trap request |

## Verification
The bound checker watches the cycle structure on every clock. It checks the one-cycle valid latency and result holding, that the side outputs stay quiet on idle cycles, and that a trap excludes both write and nullify and only follows an enabled trap. It also checks the fixed never and always codes. The lane arithmetic cannot be seen from cycle relations alone. Zero detection per lane, carries out of nibble, byte, halfword and word tops, the 32-bit truncation and the degraded word codes are checked by the bench. Its reference model recomputes each carry by adding truncated operands, across directed corner cases and a long run of operands built to hit zero lanes.

// File: rtl/unit_cond_pkg.sv
package unit_cond_pkg;

  typedef enum logic [1:0] {
    OP_UXOR   = 2'd0,
    OP_UADDCM = 2'd1,
    OP_ADD    = 2'd2,
    OP_SUB    = 2'd3
  } unitOp_e;

  // Encodings match condField[3:1]; NONE is also used for degraded codes.
  typedef enum logic [2:0] {
    TST_NONE   = 3'd0,
    TST_ZWORD  = 3'd1,
    TST_ZBYTE  = 3'd2,
    TST_ZHALF  = 3'd3,
    TST_CDIGIT = 3'd4,
    TST_CWORD  = 3'd5,
    TST_CBYTE  = 3'd6,
    TST_CHALF  = 3'd7
  } laneTest_e;

  typedef struct packed {
    logic      useXor;
    logic      invertB;
    logic      carryIn;
    logic      dword;
    laneTest_e test;
    logic      invert;
  } unitStrobe_t;

endpackage

// File: rtl/unit_cond_datapath.sv
module unit_cond_datapath
  import unit_cond_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NIBBLE_W = 4,
  parameter int BYTE_W   = 8
) (
  input  logic [DATA_W-1:0] operandA,
  input  logic [DATA_W-1:0] operandB,
  input  unitStrobe_t       strobe,
  output logic [DATA_W-1:0] resultNext,
  output logic              condRaw
);

  localparam int HALF_W = 2 * BYTE_W;
  localparam int WORD_W = DATA_W / 2;
  localparam int LOW_W  = DATA_W / 2;

  // One bit set at lane position 'pos' of every lane of width 'laneW'.
  function automatic logic [DATA_W-1:0] laneBits(input int laneW, input int pos);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < DATA_W; i++) m[i] = ((i % laneW) == pos);
    return m;
  endfunction

  localparam logic [DATA_W-1:0] ONES_WORD  = laneBits(WORD_W, 0);
  localparam logic [DATA_W-1:0] SIGN_WORD  = laneBits(WORD_W, WORD_W - 1);
  localparam logic [DATA_W-1:0] ONES_BYTE  = laneBits(BYTE_W, 0);
  localparam logic [DATA_W-1:0] SIGN_BYTE  = laneBits(BYTE_W, BYTE_W - 1);
  localparam logic [DATA_W-1:0] ONES_HALF  = laneBits(HALF_W, 0);
  localparam logic [DATA_W-1:0] SIGN_HALF  = laneBits(HALF_W, HALF_W - 1);
  localparam logic [DATA_W-1:0] SIGN_DIGIT = laneBits(NIBBLE_W, NIBBLE_W - 1);
  localparam logic [DATA_W-1:0] LOW_MASK   = {{(DATA_W-LOW_W){1'b0}}, {LOW_W{1'b1}}};

  logic [DATA_W-1:0] bEff;
  logic [DATA_W-1:0] sumLow;
  logic              carryTop;
  logic [DATA_W-1:0] carryInVec;
  logic [DATA_W-1:0] carryOutVec;
  logic [DATA_W-1:0] onesMask, signsMask, carryMask;
  logic [DATA_W-1:0] zeroProbe;
  logic              zeroHit, carryHit;

  assign bEff = strobe.invertB ? ~operandB : operandB;
  assign {carryTop, sumLow} = {1'b0, operandA} + {1'b0, bEff}
                            + {{DATA_W{1'b0}}, strobe.carryIn};
  assign resultNext = strobe.useXor ? (operandA ^ operandB) : sumLow;

  // Carry into each bit, moved down so bit i holds the carry out of bit i.
  assign carryInVec = operandA ^ bEff ^ sumLow;
  always_comb begin
    carryOutVec = carryInVec >> 1;
    carryOutVec[DATA_W-1] = strobe.dword & carryTop;
  end

  always_comb begin
    onesMask  = '0;
    signsMask = '0;
    carryMask = '0;
    unique case (strobe.test)
      TST_ZWORD:  begin onesMask = ONES_WORD; signsMask = SIGN_WORD; end
      TST_ZBYTE:  begin onesMask = ONES_BYTE; signsMask = SIGN_BYTE; end
      TST_ZHALF:  begin onesMask = ONES_HALF; signsMask = SIGN_HALF; end
      TST_CDIGIT: carryMask = SIGN_DIGIT;
      TST_CWORD:  carryMask = SIGN_WORD;
      TST_CBYTE:  carryMask = SIGN_BYTE;
      TST_CHALF:  carryMask = SIGN_HALF;
      default:    ;
    endcase
    if (!strobe.dword) begin
      onesMask  = onesMask  & LOW_MASK;
      signsMask = signsMask & LOW_MASK;
      carryMask = carryMask & LOW_MASK;
    end
  end

  assign zeroProbe = (resultNext - onesMask) & ~resultNext & signsMask;
  assign zeroHit   = |zeroProbe;
  assign carryHit  = |(carryOutVec & carryMask);
  assign condRaw   = zeroHit | carryHit;

endmodule

// File: rtl/unit_cond_ctrl.sv
module unit_cond_ctrl
  import unit_cond_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [1:0]        opSel,
  input  logic [3:0]        condField,
  input  logic              dwordMode,
  input  logic              trapEn,
  input  logic [DATA_W-1:0] resultNext,
  input  logic              condRaw,
  output unitStrobe_t       strobe,
  output logic              outValid,
  output logic [DATA_W-1:0] result,
  output logic              writeEn,
  output logic              nullifyNext,
  output logic              trapReq
);

  unitOp_e   opCode;
  laneTest_e testCode;
  logic      condTrue;
  logic      trapHit;

  assign opCode = unitOp_e'(opSel);

  always_comb begin
    testCode = laneTest_e'(condField[3:1]);
    // XOR only supports zero-lane tests
    if (opCode == OP_UXOR && condField[3]) testCode = TST_NONE;
    // word-lane tests have no meaning with a 32-bit view
    if (!dwordMode && (testCode == TST_ZWORD || testCode == TST_CWORD))
      testCode = TST_NONE;
  end

  always_comb begin
    strobe.useXor  = (opCode == OP_UXOR);
    strobe.invertB = (opCode == OP_UADDCM) || (opCode == OP_SUB);
    strobe.carryIn = (opCode == OP_SUB);
    strobe.dword   = dwordMode;
    strobe.test    = testCode;
    strobe.invert  = condField[0];
  end

  assign condTrue = condRaw ^ strobe.invert;
  assign trapHit  = trapEn & condTrue;

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid    <= 1'b0;
      result      <= '0;
      writeEn     <= 1'b0;
      nullifyNext <= 1'b0;
      trapReq     <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        result      <= resultNext;
        writeEn     <= ~trapHit;
        nullifyNext <= condTrue & ~trapEn;
        trapReq     <= trapHit;
      end else begin
        writeEn     <= 1'b0;
        nullifyNext <= 1'b0;
        trapReq     <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/unit_cond_eval.sv
module unit_cond_eval
  import unit_cond_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [1:0]        opSel,
  input  logic [DATA_W-1:0] operandA,
  input  logic [DATA_W-1:0] operandB,
  input  logic [3:0]        condField,
  input  logic              dwordMode,
  input  logic              trapEn,
  output logic              outValid,
  output logic [DATA_W-1:0] result,
  output logic              writeEn,
  output logic              nullifyNext,
  output logic              trapReq
);

  unitStrobe_t       strobe;
  logic [DATA_W-1:0] resultNext;
  logic              condRaw;

  unit_cond_datapath #(.DATA_W(DATA_W)) datapath (
    .operandA   (operandA),
    .operandB   (operandB),
    .strobe     (strobe),
    .resultNext (resultNext),
    .condRaw    (condRaw)
  );

  unit_cond_ctrl #(.DATA_W(DATA_W)) ctrl (
    .clk         (clk),
    .rst         (rst),
    .inValid     (inValid),
    .opSel       (opSel),
    .condField   (condField),
    .dwordMode   (dwordMode),
    .trapEn      (trapEn),
    .resultNext  (resultNext),
    .condRaw     (condRaw),
    .strobe      (strobe),
    .outValid    (outValid),
    .result      (result),
    .writeEn     (writeEn),
    .nullifyNext (nullifyNext),
    .trapReq     (trapReq)
  );

endmodule

// File: rtl/unit_cond_eval_chk.sv
module unit_cond_eval_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic [3:0]        condField,
  input logic              trapEn,
  input logic              outValid,
  input logic [DATA_W-1:0] result,
  input logic              writeEn,
  input logic              nullifyNext,
  input logic              trapReq
);

  p_reset_r1: assert property (@(posedge clk)
    rst |=> !outValid && !writeEn && !nullifyNext && !trapReq && result == '0);

  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);

  p_bubble_r2: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> $stable(result));

  p_never_r4: assert property (@(posedge clk) disable iff (rst)
    (inValid && condField == 4'b0000) |=> writeEn && !nullifyNext && !trapReq);

  p_always_r4: assert property (@(posedge clk) disable iff (rst)
    (inValid && condField == 4'b0001 && !trapEn) |=> writeEn && nullifyNext);

  p_trap_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    trapReq |-> !writeEn && !nullifyNext);

  p_trap_cause_r10: assert property (@(posedge clk) disable iff (rst)
    trapReq |-> $past(trapEn) && $past(inValid));

  p_idle_r12: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> !writeEn && !nullifyNext && !trapReq);

  p_one_action_r11: assert property (@(posedge clk) disable iff (rst)
    outValid |-> $onehot({writeEn, trapReq}));

endmodule

bind unit_cond_eval unit_cond_eval_chk #(.DATA_W(DATA_W)) chk (
  .clk         (clk),
  .rst         (rst),
  .inValid     (inValid),
  .condField   (condField),
  .trapEn      (trapEn),
  .outValid    (outValid),
  .result      (result),
  .writeEn     (writeEn),
  .nullifyNext (nullifyNext),
  .trapReq     (trapReq)
);

// File: tb/unit_cond_eval_test.sv
module unit_cond_eval_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 100000;

  logic        clk = 1'b0;
  logic        rst;
  logic        inValid;
  logic [1:0]  opSel;
  logic [63:0] operandA, operandB;
  logic [3:0]  condField;
  logic        dwordMode, trapEn;
  logic        outValid, writeEn, nullifyNext, trapReq;
  logic [63:0] result;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [63:0] expResult = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  unit_cond_eval uut (
    .clk(clk), .rst(rst), .inValid(inValid), .opSel(opSel),
    .operandA(operandA), .operandB(operandB), .condField(condField),
    .dwordMode(dwordMode), .trapEn(trapEn), .outValid(outValid),
    .result(result), .writeEn(writeEn), .nullifyNext(nullifyNext),
    .trapReq(trapReq)
  );

  // Carry out of bit k of (a + b + cin), from a truncated addition.
  function automatic logic carryAt(logic [63:0] a, logic [63:0] b, logic cin, int k);
    logic [64:0] m, s;
    m = (65'd1 << (k + 1)) - 65'd1;
    s = ({1'b0, a} & m) + ({1'b0, b} & m) + {64'd0, cin};
    return s[k+1];
  endfunction

  function automatic logic [63:0] refResult(logic [1:0] op, logic [63:0] a, logic [63:0] b);
    case (op)
      2'd0: return a ^ b;
      2'd1: return a + ~b;
      2'd2: return a + b;
      default: return a - b;
    endcase
  endfunction

  function automatic logic refCond(logic [1:0] op, logic [63:0] a, logic [63:0] b,
                                   logic [3:0] cf, logic dw);
    logic [63:0] r, b2;
    logic cin, hit;
    int lim, code, step, top;
    r    = refResult(op, a, b);
    b2   = (op == 2'd1 || op == 2'd3) ? ~b : b;
    cin  = (op == 2'd3);
    lim  = dw ? 64 : 32;
    code = int'(cf[3:1]);
    hit  = 1'b0;
    if (op == 2'd0 && code >= 4) code = 0;
    if (!dw && (code == 1 || code == 5)) code = 0;
    case (code)
      1: for (int l = 0; l < lim; l += 32) if (r[l +: 32] == 32'd0) hit = 1'b1;
      2: for (int l = 0; l < lim; l += 8)  if (r[l +: 8] == 8'd0) hit = 1'b1;
      3: for (int l = 0; l < lim; l += 16) if (r[l +: 16] == 16'd0) hit = 1'b1;
      default: ;
    endcase
    step = (code == 4) ? 4 : (code == 5) ? 32 : (code == 6) ? 8 : 16;
    if (code >= 4) begin
      for (int k = step - 1; k < lim; k += step) if (carryAt(a, b2, cin, k)) hit = 1'b1;
    end
    return hit ^ cf[0];
  endfunction

  task automatic report(string tag, string what, logic [63:0] act, logic [63:0] exp);
    errors++;
    $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
  endtask

  task automatic compare(string tag, logic eV, logic eW, logic eN, logic eT);
    checks++;
    if (outValid !== eV)     report(tag, "outValid", {63'd0, outValid}, {63'd0, eV});
    if (result !== expResult) report(tag, "result", result, expResult);
    if (writeEn !== eW)      report(tag, "writeEn", {63'd0, writeEn}, {63'd0, eW});
    if (nullifyNext !== eN)  report(tag, "nullifyNext", {63'd0, nullifyNext}, {63'd0, eN});
    if (trapReq !== eT)      report(tag, "trapReq", {63'd0, trapReq}, {63'd0, eT});
  endtask

  // Drive at a falling edge, let one rising edge pass, check at the next falling edge.
  task automatic step(logic v, logic [1:0] op, logic [63:0] a, logic [63:0] b,
                      logic [3:0] cf, logic dw, logic te, string tag);
    logic c;
    inValid = v; opSel = op; operandA = a; operandB = b;
    condField = cf; dwordMode = dw; trapEn = te;
    c = refCond(op, a, b, cf, dw);
    @(negedge clk);
    if (v) begin
      expResult = refResult(op, a, b);
      compare(tag, 1'b1, !(te && c), c && !te, te && c);
    end else begin
      compare(tag, 1'b0, 1'b0, 1'b0, 1'b0);
    end
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; inValid = 0; opSel = 0; operandA = 0; operandB = 0;
    condField = 0; dwordMode = 1; trapEn = 0;
    repeat (3) @(negedge clk);
    expResult = '0;
    compare("R1", 1'b0, 1'b0, 1'b0, 1'b0);  // R1 reset state
    rst = 1'b0;

    // R3 operations
    step(1, 2'd2, 64'h0123_4567_89AB_CDEF, 64'h1111_1111_1111_1111, 4'h0, 1, 0, "R3");
    step(1, 2'd3, 64'h0000_0000_0000_0005, 64'h0000_0000_0000_0009, 4'h0, 1, 0, "R3");
    step(1, 2'd1, 64'hFFFF_0000_AAAA_5555, 64'h0F0F_0F0F_0F0F_0F0F, 4'h0, 1, 0, "R3");
    step(1, 2'd0, 64'hDEAD_BEEF_CAFE_F00D, 64'h1234_5678_9ABC_DEF0, 4'h0, 1, 0, "R3");
    // R4 never / always
    step(1, 2'd2, 64'h1, 64'h2, 4'h1, 1, 0, "R4");
    step(1, 2'd0, 64'h0, 64'h0, 4'h0, 1, 0, "R4");
    // R5 zero lanes
    step(1, 2'd0, 64'hAABB_CCDD_1122_3344, 64'hAABB_CCDD_0000_0000, 4'h2, 1, 0, "R5");
    step(1, 2'd0, 64'hAABB_CCDD_1122_3344, 64'hAABB_CCDD_0000_0001, 4'h2, 1, 0, "R5");
    step(1, 2'd0, 64'h1100_2233_4455_6677, 64'h0, 4'h4, 1, 0, "R5");
    step(1, 2'd0, 64'h1100_2233_4455_6677, 64'h0, 4'h6, 1, 0, "R5");
    step(1, 2'd0, 64'h0000_2233_4455_6677, 64'h0, 4'h6, 1, 0, "R5");
    step(1, 2'd0, 64'h0101_0101_0101_0101, 64'h0, 4'h5, 1, 0, "R5");
    // R6 carries
    step(1, 2'd2, 64'h0000_0000_0000_000F, 64'h1, 4'h8, 1, 0, "R6");
    step(1, 2'd2, 64'h0000_0000_0000_000F, 64'h1, 4'hC, 1, 0, "R6");
    step(1, 2'd2, 64'h0000_0000_0000_00FF, 64'h1, 4'hC, 1, 0, "R6");
    step(1, 2'd2, 64'hFFFF_FFFF_0000_0000, 64'h1_0000_0000, 4'hA, 1, 0, "R6");
    step(1, 2'd2, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 4'hE, 1, 0, "R6");
    step(1, 2'd3, 64'h5, 64'h5, 4'hC, 1, 0, "R6");
    step(1, 2'd1, 64'h5, 64'h5, 4'hC, 1, 0, "R6");
    step(1, 2'd3, 64'h0, 64'h1, 4'hD, 1, 0, "R6");
    // R7 / R8 32-bit view
    step(1, 2'd0, 64'h0000_0000_1122_3344, 64'h0, 4'h6, 0, 0, "R7");
    step(1, 2'd0, 64'h0000_1111_1122_3344, 64'h0, 4'h4, 0, 0, "R7");
    step(1, 2'd2, 64'hFFFF_FFFF_0000_0000, 64'h1_0000_0000, 4'hE, 0, 0, "R7");
    step(1, 2'd0, 64'h0, 64'h0, 4'h2, 0, 0, "R8");
    step(1, 2'd0, 64'h0, 64'h0, 4'h3, 0, 0, "R8");
    step(1, 2'd2, 64'hFFFF_FFFF, 64'h1, 4'hA, 0, 0, "R8");
    // R9 XOR with carry codes
    step(1, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 4'hC, 1, 0, "R9");
    step(1, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 4'hD, 1, 0, "R9");
    // R10 / R11 trap
    step(1, 2'd2, 64'hFF, 64'h1, 4'hC, 1, 1, "R10");
    step(1, 2'd2, 64'h10, 64'h1, 4'hC, 1, 1, "R11");
    step(1, 2'd0, 64'h5, 64'h5, 4'h1, 1, 1, "R10");
    // R12 / R2 idle holds result
    step(0, 2'd2, 64'h9, 64'h9, 4'h1, 1, 1, "R12");
    step(0, 2'd1, 64'h7, 64'h3, 4'h3, 1, 0, "R2");

    // R2..R11 mixed stream
    for (int i = 0; i < 1500; i++) begin
      logic [63:0] a, b;
      logic [1:0] op;
      a  = {$urandom, $urandom};
      op = 2'($urandom);
      case (i % 4)
        0: b = {$urandom, $urandom};
        1: b = (op == 2'd2) ? (~a + 64'd1) : a;
        2: b = a ^ (64'hFF << (8 * ($urandom % 8)));
        default: b = ~a;
      endcase
      if (i % 7 == 3) a = a & ~(64'hFFFF << (16 * ($urandom % 4)));
      step(($urandom % 5) != 0, op, a, b, 4'($urandom), 1'($urandom), 1'(($urandom % 4) == 0),
           "R6");
    end

    // R1 reset mid-run
    step(1, 2'd2, 64'h77, 64'h88, 4'h1, 1, 0, "R11");
    rst = 1'b1; inValid = 1'b1;
    @(negedge clk);
    expResult = '0;
    compare("R1", 1'b0, 1'b0, 1'b0, 1'b0);
    rst = 1'b0;
    step(1, 2'd3, 64'h10, 64'h10, 4'h2, 1, 0, "R5");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule